// File: doc/BRIEF.md
# Parallel Converter Conversion Sequencer

This block sits on the host side of a 12-bit sampling converter that has a parallel output bus. The converter is driven by an active-low chip select and an active-low start strobe, and it reports its state on an active-low busy line. When a sample request pulse arrives, or when the free-running rate timer fires, the sequencer runs one conversion. It lowers chip select and, after a setup interval, drops the start strobe for a fixed low width. It then waits for busy to go active and later inactive. After a guard interval it latches the bus word, and it finally raises chip select for a bus-release interval. Every interval is a parameter counted in system-clock cycles. The defaults meet the converter's limits at a 100 MHz clock.

Busy is passed through a two-stage synchronizer before the controller acts on it. Because the data bus can settle slightly before or after busy returns inactive, the word is captured only after the guard interval. Conversions are spaced by a minimum strobe-to-strobe period and by a minimum quiet gap after each conversion ends. A request that arrives during a conversion is held and started as soon as spacing allows. The result is presented on a valid/ready port as the raw 12-bit two's-complement word and as a copy sign-extended to 16 bits. Missing or stuck busy activity ends the conversion with a sticky error.

Top module: `pconv_seq`

## Requirements
- R1: While reset is held and right after it, chip select and start strobe are high (1), output valid is 0, the error and overflow flags are 0 and the overrun count is 0.
- R2: Chip select falls at least SETUP_CYC (default 1) cycles before the start strobe falls. The strobe stays low for exactly LOW_CYC (default 2) cycles, and it is only ever low while chip select is low.
- R3: The output word equals the value on the data bus after the guard interval. Output valid rises no earlier than GUARD_CYC (default 3) cycles after busy returns high.
- R4: Consecutive strobe falls are at least PERIOD_CYC (default 34) cycles apart. A strobe falls at least GAP_CYC (default 5) cycles after the previous busy rise. Chip select stays high for at least RELEASE_CYC (default 4) cycles between conversions.
- R5: A request that arrives while a conversion is running is held and started afterwards, and both results are delivered in order.
- R6: A request that arrives while another is already pending is dropped and increments the overrun count. The count saturates and never decreases.
- R7: While output valid is 1 and ready is 0, valid stays 1 and the output word does not change.
- R8: If a conversion completes while the output is valid and not accepted, the new word is discarded, the output word is unchanged and the overflow flag sets and stays set.
- R9: The 16-bit output carries the 12-bit word with bit 11 copied into bits 15..12. For example, 0x800 gives 0xF800, 0x7FF gives 0x07FF and 0xFFF gives 0xFFFF.
- R10: If busy does not go low within BUSY_TO_CYC (default 4) cycles after the strobe rises, the error flag sets and stays set, chip select returns high and no word is delivered.
- R11: If busy stays low for CONV_MAX_CYC (default 30) cycles, the error flag sets, chip select and strobe return high and no word is delivered.
- R12: With free-run enabled and a rate of N cycles (N at least the conversion length), successive strobe falls are exactly N cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleReq | input | 1 | One-cycle pulse requesting one conversion |
| freeRun | input | 1 | Enables the periodic rate timer |
| rateCycles | input | 16 | Free-run period in cycles |
| adcCsN | output | 1 | Converter chip select, active low |
| adcConvstN | output | 1 | Conversion start strobe, active low |
| adcBusyN | input | 1 | Converter busy flag, low while converting |
| adcData | input | 12 | Converter parallel data bus |
| outValid | output | 1 | Result word available |
| outReady | input | 1 | Consumer accepts the result |
| outData | output | 12 | Raw two's-complement result |
| outDataSx | output | 16 | Sign-extended result |
| errFlag | output | 1 | Sticky busy-timeout error |
| overflowFlag | output | 1 | Sticky result-dropped flag |
| overrunCnt | output | 8 | Saturating count of dropped requests |

## Verification
The converter model drives the inverse of the correct word for several cycles after busy rises. A sequencer that captured without the guard delay would therefore return the complemented word. The bench sends a second request in mid-conversion and a third while the second is pending. A design that dropped the pending request would deliver one word, and one that started it early would break the strobe period. The bench stalls the consumer across a second conversion, which exposes overwriting of the held word or a missing overflow flag. Model modes with no busy response and with busy stuck low check that the sequencer raises its error and releases chip select instead of hanging.

// File: rtl/pconv_pkg.sv
package pconv_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_STROBE,
    S_WAITB,
    S_CONV,
    S_GUARD,
    S_CAPTURE,
    S_RELEASE
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic fault;
    logic overrun;
  } seqStrobe_t;

endpackage

// File: rtl/pconv_ctrl.sv
module pconv_ctrl
  import pconv_pkg::*;
#(
  parameter int SETUP_CYC    = 1,
  parameter int LOW_CYC      = 2,
  parameter int HIGH_CYC     = 2,
  parameter int GUARD_CYC    = 3,
  parameter int GAP_CYC      = 5,
  parameter int RELEASE_CYC  = 4,
  parameter int PERIOD_CYC   = 34,
  parameter int BUSY_TO_CYC  = 4,
  parameter int CONV_MAX_CYC = 30,
  parameter int SYNC_STAGES  = 2,
  parameter int RATE_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleReq,
  input  logic              freeRun,
  input  logic [RATE_W-1:0] rateCycles,
  input  logic              adcBusyN,
  output logic              csN,
  output logic              convstN,
  output seqStrobe_t        strobes
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // the strobe high time is covered by enforcing at least HIGH_CYC of quiet gap
  localparam int GAP_EFF = maxOf(GAP_CYC, HIGH_CYC);
  localparam int MAXC = maxOf(maxOf(maxOf(SETUP_CYC, LOW_CYC), maxOf(GUARD_CYC, RELEASE_CYC)),
                              maxOf(maxOf(BUSY_TO_CYC, CONV_MAX_CYC), maxOf(GAP_EFF, PERIOD_CYC)));
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETUP_END   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_END     = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_END   = CNT_W'(GUARD_CYC - 1);
  localparam logic [CNT_W-1:0] RELEASE_END = CNT_W'(RELEASE_CYC - 1);
  localparam logic [CNT_W-1:0] BUSY_END    = CNT_W'(BUSY_TO_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_END    = CNT_W'(CONV_MAX_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_FULL    = CNT_W'(GAP_EFF);
  localparam logic [CNT_W-1:0] PERIOD_END  = CNT_W'(PERIOD_CYC - 1);

  seqState_t         state, stateNext;
  logic [CNT_W-1:0]  stepCnt, gapCnt, periodCnt;
  logic [RATE_W-1:0] rateCnt;
  logic [SYNC_STAGES-1:0] busySync;
  logic              busyNs, pending, rateTick, request, start, faultNow;

  // busy arrives from another timing domain
  always_ff @(posedge clk) begin
    if (!rstN) busySync <= '1;
    else       busySync <= {busySync[SYNC_STAGES-2:0], adcBusyN};
  end
  assign busyNs = busySync[SYNC_STAGES-1];

  // free-run rate timer
  assign rateTick = freeRun && (rateCycles != '0) && (rateCnt == rateCycles - 1'b1);
  always_ff @(posedge clk) begin
    if (!rstN || !freeRun || rateTick) rateCnt <= '0;
    else                               rateCnt <= rateCnt + 1'b1;
  end

  assign request = sampleReq || rateTick;
  assign start   = (state == S_IDLE) && pending && (gapCnt >= GAP_FULL) && (periodCnt >= PERIOD_END);

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= (pending && !start) || request;
  end

  always_comb begin
    stateNext = state;
    faultNow  = 1'b0;
    unique case (state)
      S_IDLE:    if (start) stateNext = S_SETUP;
      S_SETUP:   if (stepCnt == SETUP_END) stateNext = S_STROBE;
      S_STROBE:  if (stepCnt == LOW_END) stateNext = S_WAITB;
      S_WAITB: begin
        if (!busyNs) stateNext = S_CONV;
        else if (stepCnt == BUSY_END) begin
          faultNow  = 1'b1;
          stateNext = S_RELEASE;
        end
      end
      S_CONV: begin
        if (busyNs) stateNext = S_GUARD;
        else if (stepCnt == CONV_END) begin
          faultNow  = 1'b1;
          stateNext = S_RELEASE;
        end
      end
      S_GUARD:   if (stepCnt == GUARD_END) stateNext = S_CAPTURE;
      S_CAPTURE: stateNext = S_RELEASE;
      S_RELEASE: if (stepCnt == RELEASE_END) stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stepCnt   <= '0;
      gapCnt    <= GAP_FULL;
      periodCnt <= PERIOD_END;
    end else begin
      state <= stateNext;
      if (stateNext != state || state == S_IDLE) stepCnt <= '0;
      else                                       stepCnt <= stepCnt + 1'b1;
      if (state == S_CONV && busyNs) gapCnt <= '0;
      else if (gapCnt < GAP_FULL)    gapCnt <= gapCnt + 1'b1;
      if (start)                        periodCnt <= '0;
      else if (periodCnt < PERIOD_END)  periodCnt <= periodCnt + 1'b1;
    end
  end

  assign csN     = (state == S_IDLE) || (state == S_RELEASE);
  assign convstN = (state != S_STROBE);

  assign strobes.capture = (state == S_CAPTURE);
  assign strobes.fault   = faultNow;
  assign strobes.overrun = request && pending && !start;

endmodule

// File: rtl/pconv_dpath.sv
module pconv_dpath
  import pconv_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int EXT_W  = 16,
  parameter int OVR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [DATA_W-1:0] adcData,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [EXT_W-1:0]  outDataSx,
  output logic              errFlag,
  output logic              overflowFlag,
  output logic [OVR_W-1:0]  overrunCnt
);

  localparam int PAD_W = EXT_W - DATA_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outData      <= '0;
      overflowFlag <= 1'b0;
      errFlag      <= 1'b0;
      overrunCnt   <= '0;
    end else begin
      if (strobes.capture) begin
        if (outValid && !outReady) begin
          overflowFlag <= 1'b1;
        end else begin
          outData  <= adcData;
          outValid <= 1'b1;
        end
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end
      if (strobes.fault) errFlag <= 1'b1;
      if (strobes.overrun && overrunCnt != '1) overrunCnt <= overrunCnt + 1'b1;
    end
  end

  assign outDataSx = {{PAD_W{outData[DATA_W-1]}}, outData};

endmodule

// File: rtl/pconv_seq.sv
module pconv_seq
  import pconv_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int EXT_W        = 16,
  parameter int OVR_W        = 8,
  parameter int RATE_W       = 16,
  parameter int SETUP_CYC    = 1,
  parameter int LOW_CYC      = 2,
  parameter int HIGH_CYC     = 2,
  parameter int GUARD_CYC    = 3,
  parameter int GAP_CYC      = 5,
  parameter int RELEASE_CYC  = 4,
  parameter int PERIOD_CYC   = 34,
  parameter int BUSY_TO_CYC  = 4,
  parameter int CONV_MAX_CYC = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleReq,
  input  logic              freeRun,
  input  logic [RATE_W-1:0] rateCycles,
  output logic              adcCsN,
  output logic              adcConvstN,
  input  logic              adcBusyN,
  input  logic [DATA_W-1:0] adcData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [EXT_W-1:0]  outDataSx,
  output logic              errFlag,
  output logic              overflowFlag,
  output logic [OVR_W-1:0]  overrunCnt
);

  seqStrobe_t strobes;

  pconv_ctrl #(
    .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC),
    .GUARD_CYC(GUARD_CYC), .GAP_CYC(GAP_CYC), .RELEASE_CYC(RELEASE_CYC),
    .PERIOD_CYC(PERIOD_CYC), .BUSY_TO_CYC(BUSY_TO_CYC),
    .CONV_MAX_CYC(CONV_MAX_CYC), .SYNC_STAGES(2), .RATE_W(RATE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .freeRun(freeRun),
    .rateCycles(rateCycles), .adcBusyN(adcBusyN),
    .csN(adcCsN), .convstN(adcConvstN), .strobes(strobes)
  );

  pconv_dpath #(.DATA_W(DATA_W), .EXT_W(EXT_W), .OVR_W(OVR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .adcData(adcData),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outDataSx(outDataSx), .errFlag(errFlag), .overflowFlag(overflowFlag),
    .overrunCnt(overrunCnt)
  );

endmodule

// File: rtl/pconv_seq_chk.sv
module pconv_seq_chk #(
  parameter int DATA_W      = 12,
  parameter int OVR_W       = 8,
  parameter int RELEASE_CYC = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              adcCsN,
  input logic              adcConvstN,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              errFlag,
  input logic              overflowFlag,
  input logic [OVR_W-1:0]  overrunCnt
);

  assert_strobe_under_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !adcConvstN |-> !adcCsN);

  assert_cs_led_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcConvstN) |-> $past(!adcCsN));

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  assert_overrun_monotonic_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (overrunCnt >= $past(overrunCnt)));

  generate
    if (RELEASE_CYC > 1) begin : g_release
      assert_release_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
        $rose(adcCsN) |=> adcCsN);
    end
  endgenerate

endmodule

bind pconv_seq pconv_seq_chk #(.DATA_W(DATA_W), .OVR_W(OVR_W), .RELEASE_CYC(RELEASE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .adcCsN(adcCsN), .adcConvstN(adcConvstN),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .errFlag(errFlag), .overflowFlag(overflowFlag), .overrunCnt(overrunCnt)
);

// File: tb/pconv_seq_bench.sv
`timescale 1ns/1ps
module pconv_seq_bench;

  localparam int SETUP_CYC   = 1;
  localparam int LOW_CYC     = 2;
  localparam int GUARD_CYC   = 3;
  localparam int GAP_CYC     = 5;
  localparam int RELEASE_CYC = 4;
  localparam int PERIOD_CYC  = 34;
  localparam int MODEL_CONV  = 24;
  localparam int MODEL_LAG   = 3;
  localparam int NVEC        = 6;
  // {bus word, expected sign-extended word}
  localparam logic [27:0] VEC [NVEC] = '{
    {12'h000, 16'h0000}, {12'h7FF, 16'h07FF}, {12'h800, 16'hF800},
    {12'hFFF, 16'hFFFF}, {12'h123, 16'h0123}, {12'hA5C, 16'hFA5C}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleReq = 1'b0;
  logic        freeRun = 1'b0;
  logic [15:0] rateCycles = 16'd0;
  logic        adcCsN, adcConvstN;
  logic        adcBusyN = 1'b1;
  logic [11:0] adcData = 12'h0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [11:0] outData;
  logic [15:0] outDataSx;
  logic        errFlag, overflowFlag;
  logic [7:0]  overrunCnt;

  pconv_seq u_pconv_seq (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .freeRun(freeRun),
    .rateCycles(rateCycles), .adcCsN(adcCsN), .adcConvstN(adcConvstN),
    .adcBusyN(adcBusyN), .adcData(adcData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outDataSx(outDataSx),
    .errFlag(errFlag), .overflowFlag(overflowFlag), .overrunCnt(overrunCnt)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nCompared = 0, nMismatched = 0;
  int monCompared = 0, monMismatched = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic monCheck(input string req, input int act, input int bound, input bit exact);
    monCompared++;
    if (exact ? (act != bound) : (act < bound)) begin
      monMismatched++;
      $display("FAIL %s actual=%0d expected=%s%0d", req, act, exact ? "" : ">=", bound);
    end
  endtask

  // behavioural converter: busy low during conversion, bus wrong for a while after busy rises
  logic [11:0] mw [32];
  logic        noBusy = 1'b0, stuck = 1'b0;
  int          mIdx = 0, convLeft = 0, lag = 0, busyRiseCyc = 0;
  bit          mActive = 0, haveBusy = 0;
  logic        mPrevConv = 1'b1;

  always @(negedge clk) begin
    if (!rstN) begin
      mIdx <= 0; mActive <= 0; lag <= 0; adcBusyN <= 1'b1; mPrevConv <= 1'b1; haveBusy <= 0;
    end else begin
      mPrevConv <= adcConvstN;
      if (mPrevConv && !adcConvstN && !adcCsN) begin
        if (!noBusy) begin
          adcBusyN <= 1'b0; convLeft <= MODEL_CONV; mActive <= 1;
        end
      end else if (mActive) begin
        if (convLeft == 0) begin
          if (!stuck) begin
            adcBusyN <= 1'b1; mActive <= 0; adcData <= ~mw[mIdx[4:0]];
            lag <= MODEL_LAG; busyRiseCyc <= cyc; haveBusy <= 1;
          end
        end else convLeft <= convLeft - 1;
      end
      if (lag != 0) begin
        lag <= lag - 1;
        if (lag == 1) begin
          adcData <= mw[mIdx[4:0]];
          mIdx <= mIdx + 1;
        end
      end
    end
  end

  // result collector
  logic [11:0] rxData [64];
  logic [15:0] rxSx   [64];
  int          rxCount = 0;
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      rxData[rxCount[5:0]] <= outData;
      rxSx[rxCount[5:0]]   <= outDataSx;
      rxCount <= rxCount + 1;
    end
  end

  // interface timing monitor
  logic pCs = 1'b1, pCv = 1'b1, pV = 1'b0;
  int   csFall = 0, csRise = 0, strobeCyc = 0, spacing = 0, strobeCnt = 0;
  bit   haveCsRise = 0, haveStrobe = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      pCs = 1'b1; pCv = 1'b1; pV = 1'b0; haveCsRise = 0; haveStrobe = 0;
    end else begin
      if (pCs && !adcCsN) begin
        csFall = cyc;
        if (haveCsRise) monCheck("R4 chip-select release", cyc - csRise, RELEASE_CYC, 0);
      end
      if (!pCs && adcCsN) begin csRise = cyc; haveCsRise = 1; end
      if (pCv && !adcConvstN) begin
        monCheck("R2 setup before strobe", cyc - csFall, SETUP_CYC, 0);
        if (haveStrobe) begin
          spacing = cyc - strobeCyc;
          monCheck("R4 strobe period", spacing, PERIOD_CYC, 0);
        end
        if (haveBusy) monCheck("R4 gap after busy", cyc - busyRiseCyc, GAP_CYC, 0);
        strobeCyc = cyc; haveStrobe = 1; strobeCnt++;
      end
      if (!pCv && adcConvstN) monCheck("R2 strobe low width", cyc - strobeCyc, LOW_CYC, 1);
      if (!pV && outValid) monCheck("R3 capture guard", cyc - busyRiseCyc, GUARD_CYC, 0);
      pCs = adcCsN; pCv = adcConvstN; pV = outValid;
    end
  end

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseReq();
    @(negedge clk); sampleReq = 1'b1;
    @(negedge clk); sampleReq = 1'b0;
  endtask

  task automatic waitRx(input int target);
    for (int k = 0; k < 400 && rxCount < target; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             nCompared + monCompared, nMismatched + monMismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCompared++; nMismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  int wIdx = 0;
  int base;
  logic [11:0] held;

  initial begin
    for (int i = 0; i < 32; i++) mw[i] = 12'h0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 csN in reset", 32'(adcCsN), 32'd1);
    check("R1 convstN in reset", 32'(adcConvstN), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 errFlag", 32'(errFlag), 32'd0);
    check("R1 overflowFlag", 32'(overflowFlag), 32'd0);
    check("R1 overrunCnt", 32'(overrunCnt), 32'd0);

    // R3 / R9: vector table
    for (int i = 0; i < NVEC; i++) begin
      mw[wIdx[4:0]] = VEC[i][27:16];
      wIdx++;
      base = rxCount;
      pulseReq();
      waitRx(base + 1);
      check("R3 captured word", 32'(rxData[base[5:0]]), 32'(VEC[i][27:16]));
      check("R9 sign-extended word", 32'(rxSx[base[5:0]]), 32'(VEC[i][15:0]));
    end

    // R5: request during a conversion is held
    mw[wIdx[4:0]] = 12'h3C1; mw[(wIdx + 1) & 31] = 12'hC3E; wIdx += 2;
    base = rxCount;
    pulseReq();
    repeat (8) @(negedge clk);
    pulseReq();
    waitRx(base + 2);
    check("R5 results delivered", 32'(rxCount - base), 32'd2);
    check("R5 first word", 32'(rxData[base[5:0]]), 32'h3C1);
    check("R5 held word", 32'(rxData[(base + 1) & 63]), 32'hC3E);

    // R6: third request while one pending
    doReset(); wIdx = 0;
    mw[0] = 12'h111; mw[1] = 12'h222; wIdx = 2;
    base = rxCount;
    pulseReq();
    repeat (5) @(negedge clk);
    pulseReq();
    repeat (2) @(negedge clk);
    pulseReq();
    waitRx(base + 2);
    repeat (80) @(negedge clk);
    check("R6 overrun count", 32'(overrunCnt), 32'd1);
    check("R6 dropped request made no word", 32'(rxCount - base), 32'd2);
    check("R6 order", 32'(rxData[(base + 1) & 63]), 32'h222);

    // R7 / R8: stalled consumer
    outReady = 1'b0;
    mw[wIdx[4:0]] = 12'h5A5; mw[(wIdx + 1) & 31] = 12'h0F0; wIdx += 2;
    pulseReq();
    for (int k = 0; k < 200 && !outValid; k++) @(negedge clk);
    check("R7 word presented", 32'(outData), 32'h5A5);
    held = outData;
    repeat (20) @(negedge clk);
    check("R7 valid held", 32'(outValid), 32'd1);
    check("R7 word stable", 32'(outData), 32'(held));
    check("R8 no overflow yet", 32'(overflowFlag), 32'd0);
    pulseReq();
    repeat (60) @(negedge clk);
    check("R8 overflow flag", 32'(overflowFlag), 32'd1);
    check("R8 word unchanged", 32'(outData), 32'h5A5);
    outReady = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 valid drops after accept", 32'(outValid), 32'd0);
    check("R8 flag sticky", 32'(overflowFlag), 32'd1);

    // R10: busy never asserts
    doReset(); wIdx = 0;
    noBusy = 1'b1;
    base = rxCount;
    pulseReq();
    repeat (25) @(negedge clk);
    check("R10 error flag", 32'(errFlag), 32'd1);
    check("R10 chip select released", 32'(adcCsN), 32'd1);
    check("R10 no word", 32'(outValid), 32'd0);
    noBusy = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 error sticky", 32'(errFlag), 32'd1);

    // R11: busy stuck low
    doReset(); wIdx = 0;
    stuck = 1'b1;
    pulseReq();
    repeat (60) @(negedge clk);
    check("R11 error flag", 32'(errFlag), 32'd1);
    check("R11 chip select released", 32'(adcCsN), 32'd1);
    check("R11 strobe high", 32'(adcConvstN), 32'd1);
    check("R11 no word", 32'(outValid), 32'd0);
    stuck = 1'b0;
    repeat (20) @(negedge clk);

    // R12: free-run rate
    doReset(); wIdx = 0;
    for (int i = 0; i < 8; i++) mw[i] = 12'(i * 97);
    rateCycles = 16'd60;
    freeRun = 1'b1;
    base = strobeCnt;
    for (int k = 0; k < 1000 && strobeCnt < base + 4; k++) @(negedge clk);
    check("R12 strobe spacing", 32'(spacing), 32'd60);
    check("R12 strobes seen", 32'(strobeCnt - base), 32'd4);
    freeRun = 1'b0;
    repeat (80) @(negedge clk);
    check("R12 no overrun", 32'(overrunCnt), 32'd0);

    finishRun();
  end

endmodule